// File: doc/BRIEF.md
# Path-History Indirect Target Predictor

This block guesses where an indirect branch will jump, for use inside an on-chip program trace generator. A software replayer keeps an identical copy of the predictor. The trace generator therefore only has to emit a record when the guess is wrong. The table is two-way set-associative. Its set index and tag are formed by XOR-folding a short path-history register with bits of the branch address, so one branch site can own different entries depending on how execution reached it.

Each entry keeps only the low part of a target, meaning the bits just above the word alignment. The upper part of every predicted target comes from one shared last-value register. When a retiring taken indirect branch carries upper bits that differ from that register, the block flags it. The trace record must then carry the full address, and the register takes on the new upper bits.

The lookup port is purely combinational and changes no state. All training happens on the retirement port: the path register, the table, the replacement bits and the last-value register.

Top module: `itgt_path_predictor`

## Requirements
- R1: After reset, every table entry is invalid, the path register is zero and the last-value register is zero. Any lookup then gives `lk_hit`=0 and `lk_target`=0.
- R2: On each cycle with `rt_valid`=1, the path register becomes ((old << 2) XOR `rt_pc`[16:4]) OR `rt_taken`, kept to 13 bits. With `rt_valid`=0 it holds its value.
- R3: For a branch address A and the current path P, the set is P[12:8] XOR A[8:4] (32 sets) and the tag is P[7:0] XOR A[17:10]. Address bits outside these fields do not affect the lookup.
- R4: `lk_hit` is 1 exactly when a valid way of the selected set holds the computed tag. `lk_target` is then {last-value register (12 bits), stored low field (18 bits), 2'b00}. On a miss it is 0.
- R5: The table is written only when `rt_valid`, `rt_indirect` and `rt_taken` are all 1. The stored field is `rt_target`[19:2]. A not-taken or non-indirect retirement writes nothing.
- R6: Each set has one replacement bit naming its least recently written way. An update whose tag already lives in the set rewrites that way. Otherwise it takes the way the bit names. Either way, the bit then points to the other way.
- R7: `rt_hi_miss` is 1 when a taken indirect branch retires with `rt_target`[31:20] different from the last-value register. On that cycle the register loads those bits. No other retirement changes it.
- R8: A lookup alone changes no state. With `rt_valid`=0, repeating a lookup address gives the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | 32 | Address of the branch being predicted |
| lk_hit | output | 1 | A valid matching entry was found |
| lk_target | output | 32 | Predicted target, zero on a miss |
| rt_valid | input | 1 | A branch retires this cycle |
| rt_pc | input | 32 | Address of the retiring branch |
| rt_target | input | 32 | Actual target of the retiring branch |
| rt_taken | input | 1 | Retiring branch was taken |
| rt_indirect | input | 1 | Retiring branch is indirect and takes part in target prediction |
| rt_hi_miss | output | 1 | Upper target bits differ from the last-value register, so a full address is required |

## Verification
The assertions assume that the retirement fields carry known values whenever `rt_valid` is high. They also assume that the table is never written except through the retirement port, which is what keeps a tag from appearing in two ways of one set. The lookup-stability property assumes that `lk_pc` is the only changing input while no branch retires. The stimulus drives every retirement field on the falling edge together with `rt_valid` and drops `rt_valid` right after the commit edge. To aim at a chosen set and tag, it builds branch addresses from a running model of the path register, so aliasing, eviction and the ignored-update cases reach exactly the entries they target.

// File: rtl/itp_pkg.sv
package itp_pkg;
   localparam int unsigned DEF_ADDR_W     = 32;
   localparam int unsigned DEF_PATH_W     = 13;
   localparam int unsigned DEF_SETS       = 32;
   localparam int unsigned DEF_WAYS       = 2;
   localparam int unsigned DEF_TAG_W      = 8;
   localparam int unsigned DEF_LOW_W      = 18;
   localparam int unsigned DEF_ALIGN      = 2;
   localparam int unsigned DEF_PC_LSB     = 4;
   localparam int unsigned DEF_TAG_PC_LSB = 10;
   localparam int unsigned DEF_PATH_SHIFT = 2;

   // Kind of table write requested by a retiring branch
   typedef enum logic [1:0] {
      WR_IDLE    = 2'd0,
      WR_REFRESH = 2'd1,
      WR_ALLOC   = 2'd2
   } wr_kind_e;
endpackage

// File: rtl/itp_hash.sv
module itp_hash #(
   parameter int unsigned ADDR_W     = itp_pkg::DEF_ADDR_W,
   parameter int unsigned PATH_W     = itp_pkg::DEF_PATH_W,
   parameter int unsigned IDX_W      = 5,
   parameter int unsigned TAG_W      = itp_pkg::DEF_TAG_W,
   parameter int unsigned PC_LSB     = itp_pkg::DEF_PC_LSB,
   parameter int unsigned TAG_PC_LSB = itp_pkg::DEF_TAG_PC_LSB
) (
   input  logic [PATH_W-1:0] path,
   input  logic [ADDR_W-1:0] pc,
   output logic [IDX_W-1:0]  idx,
   output logic [TAG_W-1:0]  tag
);
   generate
      if (IDX_W + TAG_W != PATH_W) begin : g_bad_split
         $error("itp_hash: index and tag widths must cover the path register");
      end
      if (TAG_PC_LSB + TAG_W > ADDR_W || PC_LSB + IDX_W > ADDR_W) begin : g_bad_pc
         $error("itp_hash: hashed address fields exceed the address width");
      end
   endgenerate

   // Upper path bits fold into the set, lower path bits into the tag
   assign idx = path[PATH_W-1 -: IDX_W] ^ pc[PC_LSB +: IDX_W];
   assign tag = path[TAG_W-1:0]         ^ pc[TAG_PC_LSB +: TAG_W];

   logic unused_pc_bits;
   assign unused_pc_bits = ^pc;
endmodule

// File: rtl/itp_path_reg.sv
module itp_path_reg #(
   parameter int unsigned ADDR_W     = itp_pkg::DEF_ADDR_W,
   parameter int unsigned PATH_W     = itp_pkg::DEF_PATH_W,
   parameter int unsigned PC_LSB     = itp_pkg::DEF_PC_LSB,
   parameter int unsigned PATH_SHIFT = itp_pkg::DEF_PATH_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              taken,
   input  logic [ADDR_W-1:0] pc,
   output logic [PATH_W-1:0] path
);
   generate
      if (PATH_SHIFT == 0 || PATH_SHIFT >= PATH_W) begin : g_bad_shift
         $error("itp_path_reg: shift must lie inside the register");
      end
      if (PC_LSB + PATH_W > ADDR_W) begin : g_bad_fold
         $error("itp_path_reg: folded address field exceeds the address width");
      end
   endgenerate

   logic [PATH_W-1:0] path_r;
   logic [PATH_W-1:0] fold_bits;

   assign fold_bits = pc[PC_LSB +: PATH_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         path_r <= '0;
      end else if (step) begin
         path_r <= ((path_r << PATH_SHIFT) ^ fold_bits) | {{(PATH_W-1){1'b0}}, taken};
      end
   end

   assign path = path_r;

   logic unused_pc_bits;
   assign unused_pc_bits = ^pc;

   // R2: path holds when nothing retires
   a_r2_path_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(path_r));
   // R2: a taken outcome always leaves bit 0 set
   a_r2_taken_sets_lsb: assert property (@(posedge clk) disable iff (!rst_n)
      (step && taken) |=> path_r[0]);
endmodule

// File: rtl/itp_hi_reg.sv
module itp_hi_reg #(
   parameter int unsigned HI_W = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step,
   input  logic [HI_W-1:0] hi_in,
   output logic [HI_W-1:0] hi_last,
   output logic            hi_same
);
   generate
      if (HI_W == 0) begin : g_bad_hi
         $error("itp_hi_reg: upper field must be non-empty");
      end
   endgenerate

   logic [HI_W-1:0] hi_r;

   assign hi_same = (hi_in == hi_r);
   assign hi_last = hi_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_r <= '0;
      end else if (step && !hi_same) begin
         hi_r <= hi_in;
      end
   end

   // R7: a differing upper field is adopted on the next edge
   a_r7_adopt_new_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !hi_same) |=> (hi_r == $past(hi_in)));
   // R7: only taken indirect retirements move the register
   a_r7_hold_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(hi_r));
endmodule

// File: rtl/itp_way_array.sv
module itp_way_array
   import itp_pkg::*;
#(
   parameter int unsigned SETS   = itp_pkg::DEF_SETS,
   parameter int unsigned WAYS   = itp_pkg::DEF_WAYS,
   parameter int unsigned TAG_W  = itp_pkg::DEF_TAG_W,
   parameter int unsigned DATA_W = itp_pkg::DEF_LOW_W,
   localparam int unsigned IDX_W = $clog2(SETS),
   localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [TAG_W-1:0]  rd_tag,
   output logic              rd_hit,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [DATA_W-1:0] wr_data
);
   generate
      if (WAYS != 2) begin : g_bad_ways
         $error("itp_way_array: single-bit replacement needs exactly two ways");
      end
      if ((1 << IDX_W) != SETS) begin : g_bad_sets
         $error("itp_way_array: set count must be a power of two");
      end
   endgenerate

   logic [SETS-1:0][WAYS-1:0]  valid_q;
   logic [SETS-1:0][WAY_W-1:0] lru_q;
   logic [TAG_W-1:0]           tag_q  [SETS][WAYS];
   logic [DATA_W-1:0]          data_q [SETS][WAYS];

   logic [WAYS-1:0]  rd_match;
   logic [WAYS-1:0]  wr_match;
   logic [WAY_W-1:0] hit_way;
   logic [WAY_W-1:0] wr_way;
   wr_kind_e         wr_kind;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign rd_match[w] = valid_q[rd_idx][w] && (tag_q[rd_idx][w] == rd_tag);
      assign wr_match[w] = valid_q[wr_idx][w] && (tag_q[wr_idx][w] == wr_tag);
   end

   assign rd_hit = |rd_match;

   always_comb begin
      rd_data = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (rd_match[w]) rd_data = rd_data | data_q[rd_idx][w];
      end
   end

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (wr_match[w]) hit_way = WAY_W'(w);
      end
   end

   always_comb begin
      if (!wr_en)         wr_kind = WR_IDLE;
      else if (|wr_match) wr_kind = WR_REFRESH;
      else                wr_kind = WR_ALLOC;
   end

   assign wr_way = (wr_kind == WR_REFRESH) ? hit_way : lru_q[wr_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         lru_q   <= '0;
      end else if (wr_kind != WR_IDLE) begin
         valid_q[wr_idx][wr_way] <= 1'b1;
         lru_q[wr_idx]           <= ~wr_way;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_kind != WR_IDLE) begin
         tag_q[wr_idx][wr_way]  <= wr_tag;
         data_q[wr_idx][wr_way] <= wr_data;
      end
   end

   // R4: a tag never lives in two ways of one set
   a_r4_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rd_match));
   // R6: after any write the set's victim is the other way
   a_r6_victim_moves: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (lru_q[$past(wr_idx)] != $past(wr_way)));
   // R5: without a write request no entry becomes valid
   a_r5_quiet_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(valid_q));
endmodule

// File: rtl/itgt_path_predictor.sv
module itgt_path_predictor #(
   parameter int unsigned ADDR_W     = itp_pkg::DEF_ADDR_W,
   parameter int unsigned PATH_W     = itp_pkg::DEF_PATH_W,
   parameter int unsigned SETS       = itp_pkg::DEF_SETS,
   parameter int unsigned WAYS       = itp_pkg::DEF_WAYS,
   parameter int unsigned TAG_W      = itp_pkg::DEF_TAG_W,
   parameter int unsigned LOW_W      = itp_pkg::DEF_LOW_W,
   parameter int unsigned ALIGN      = itp_pkg::DEF_ALIGN,
   parameter int unsigned PC_LSB     = itp_pkg::DEF_PC_LSB,
   parameter int unsigned TAG_PC_LSB = itp_pkg::DEF_TAG_PC_LSB,
   parameter int unsigned PATH_SHIFT = itp_pkg::DEF_PATH_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] lk_pc,
   output logic              lk_hit,
   output logic [ADDR_W-1:0] lk_target,
   input  logic              rt_valid,
   input  logic [ADDR_W-1:0] rt_pc,
   input  logic [ADDR_W-1:0] rt_target,
   input  logic              rt_taken,
   input  logic              rt_indirect,
   output logic              rt_hi_miss
);
   localparam int unsigned IDX_W = $clog2(SETS);
   localparam int unsigned HI_W  = ADDR_W - LOW_W - ALIGN;

   generate
      if (ALIGN == 0 || LOW_W + ALIGN >= ADDR_W) begin : g_bad_fields
         $error("itgt_path_predictor: target split leaves no upper field");
      end
      if (IDX_W + TAG_W != PATH_W) begin : g_bad_path
         $error("itgt_path_predictor: path width must equal index plus tag");
      end
   endgenerate

   logic [PATH_W-1:0] path_q;
   logic [IDX_W-1:0]  lk_idx, rt_idx;
   logic [TAG_W-1:0]  lk_tag, rt_tag;
   logic              tbl_hit;
   logic [LOW_W-1:0]  tbl_low;
   logic              train;
   logic [HI_W-1:0]   hi_last;
   logic              hi_same;

   assign train = rt_valid && rt_indirect && rt_taken;

   itp_path_reg #(
      .ADDR_W(ADDR_W), .PATH_W(PATH_W), .PC_LSB(PC_LSB), .PATH_SHIFT(PATH_SHIFT)
   ) u_path (
      .clk(clk), .rst_n(rst_n), .step(rt_valid), .taken(rt_taken),
      .pc(rt_pc), .path(path_q)
   );

   itp_hash #(
      .ADDR_W(ADDR_W), .PATH_W(PATH_W), .IDX_W(IDX_W), .TAG_W(TAG_W),
      .PC_LSB(PC_LSB), .TAG_PC_LSB(TAG_PC_LSB)
   ) u_lk_hash (
      .path(path_q), .pc(lk_pc), .idx(lk_idx), .tag(lk_tag)
   );

   itp_hash #(
      .ADDR_W(ADDR_W), .PATH_W(PATH_W), .IDX_W(IDX_W), .TAG_W(TAG_W),
      .PC_LSB(PC_LSB), .TAG_PC_LSB(TAG_PC_LSB)
   ) u_rt_hash (
      .path(path_q), .pc(rt_pc), .idx(rt_idx), .tag(rt_tag)
   );

   itp_way_array #(
      .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(LOW_W)
   ) u_array (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(lk_idx), .rd_tag(lk_tag), .rd_hit(tbl_hit), .rd_data(tbl_low),
      .wr_en(train), .wr_idx(rt_idx), .wr_tag(rt_tag),
      .wr_data(rt_target[ALIGN +: LOW_W])
   );

   itp_hi_reg #(.HI_W(HI_W)) u_hi (
      .clk(clk), .rst_n(rst_n), .step(train),
      .hi_in(rt_target[ADDR_W-1 -: HI_W]), .hi_last(hi_last), .hi_same(hi_same)
   );

   assign lk_hit     = tbl_hit;
   assign lk_target  = tbl_hit ? {hi_last, tbl_low, {ALIGN{1'b0}}} : '0;
   assign rt_hi_miss = train && !hi_same;

   logic unused_align_bits;
   assign unused_align_bits = ^rt_target[ALIGN-1:0];

   // R8: with no retirement and a steady lookup address, the answer is steady
   a_r8_lookup_pure: assert property (@(posedge clk) disable iff (!rst_n)
      !rt_valid |=> (!$stable(lk_pc) || ($stable(lk_hit) && $stable(lk_target))));
   // R4: a miss never presents a target
   a_r4_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_target == '0));
endmodule

// File: tb/sim_itgt_path_predictor.sv
module sim_itgt_path_predictor;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] lk_pc = '0;
   logic        lk_hit;
   logic [31:0] lk_target;
   logic        rt_valid = 1'b0;
   logic [31:0] rt_pc = '0;
   logic [31:0] rt_target = '0;
   logic        rt_taken = 1'b0;
   logic        rt_indirect = 1'b0;
   logic        rt_hi_miss;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   itgt_path_predictor u0 (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_target(lk_target),
      .rt_valid(rt_valid), .rt_pc(rt_pc), .rt_target(rt_target), .rt_taken(rt_taken),
      .rt_indirect(rt_indirect), .rt_hi_miss(rt_hi_miss)
   );

   // Reference model built from the requirements
   logic [12:0] path_m;
   logic [11:0] lv_m;
   bit          mv  [32][2];
   logic [7:0]  mt  [32][2];
   logic [17:0] md  [32][2];
   bit          mlru[32];

   function automatic logic [4:0] m_idx(input logic [12:0] p, input logic [31:0] a);
      return p[12:8] ^ a[8:4];
   endfunction
   function automatic logic [7:0] m_tag(input logic [12:0] p, input logic [31:0] a);
      return p[7:0] ^ a[17:10];
   endfunction
   // Address that lands on a chosen set and tag under path p
   function automatic logic [31:0] pc_for(input logic [12:0] p, input logic [4:0] s,
                                          input logic [7:0] t, input logic [31:0] base);
      logic [31:0] a;
      a = base;
      a[8:4]   = s ^ p[12:8];
      a[17:10] = t ^ p[7:0];
      return a;
   endfunction

   task automatic m_clear();
      path_m = '0;
      lv_m   = '0;
      for (int s = 0; s < 32; s++) begin
         mlru[s] = 1'b0;
         for (int w = 0; w < 2; w++) mv[s][w] = 1'b0;
      end
   endtask

   task automatic m_lookup(input logic [31:0] a, output logic h, output logic [31:0] t);
      logic [4:0] s;
      logic [7:0] g;
      s = m_idx(path_m, a);
      g = m_tag(path_m, a);
      h = 1'b0;
      t = '0;
      for (int w = 0; w < 2; w++) begin
         if (mv[s][w] && mt[s][w] == g) begin
            h = 1'b1;
            t = {lv_m, md[s][w], 2'b00};
         end
      end
   endtask

   task automatic m_retire(input logic [31:0] a, input logic [31:0] tg,
                           input logic tk, input logic ind);
      logic [4:0] s;
      logic [7:0] g;
      int way;
      if (ind && tk) begin
         s = m_idx(path_m, a);
         g = m_tag(path_m, a);
         way = mlru[s] ? 1 : 0;
         for (int w = 0; w < 2; w++) if (mv[s][w] && mt[s][w] == g) way = w;
         mv[s][way] = 1'b1;
         mt[s][way] = g;
         md[s][way] = tg[19:2];
         mlru[s] = (way == 0);
         if (tg[31:20] != lv_m) lv_m = tg[31:20];
      end
      path_m = ((path_m << 2) ^ a[16:4]) | {12'd0, tk};
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      rt_valid = 1'b0;
      m_clear();
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Lookup only; compares against the model
   task automatic probe(input logic [31:0] a, input string req);
      logic h;
      logic [31:0] t;
      @(negedge clk);
      rt_valid = 1'b0;
      lk_pc = a;
      #2;
      m_lookup(a, h, t);
      chk({req, " hit"}, 32'(lk_hit), 32'(h));
      chk({req, " target"}, lk_target, t);
   endtask

   // Lookup of the same address plus a retirement in one cycle
   task automatic step(input logic [31:0] a, input logic [31:0] tg,
                       input logic tk, input logic ind);
      logic h;
      logic [31:0] t;
      @(negedge clk);
      lk_pc = a;
      rt_valid = 1'b1;
      rt_pc = a;
      rt_target = tg;
      rt_taken = tk;
      rt_indirect = ind;
      #2;
      m_lookup(a, h, t);
      chk("R4 step hit", 32'(lk_hit), 32'(h));
      chk("R4 step target", lk_target, t);
      chk("R7 step hi_miss", 32'(rt_hi_miss), 32'(ind && tk && (tg[31:20] != lv_m)));
      @(posedge clk);
      m_retire(a, tg, tk, ind);
      #1;
      rt_valid = 1'b0;
   endtask

   typedef struct packed {
      logic [31:0] pc;
      logic [31:0] tgt;
      logic        tk;
      logic        ind;
   } vec_t;

   localparam int VEC_N = 12;
   localparam vec_t VECS [VEC_N] = '{
      '{32'h0000_0100, 32'h0000_0140, 1'b1, 1'b0},
      '{32'h0000_0180, 32'h0001_0400, 1'b1, 1'b1},
      '{32'h0001_0420, 32'h0000_0000, 1'b0, 1'b0},
      '{32'h0001_04f0, 32'h0000_0184, 1'b1, 1'b1},
      '{32'h0000_0200, 32'h0002_2000, 1'b1, 1'b1},
      '{32'h0002_2010, 32'h0000_0000, 1'b0, 1'b1},
      '{32'h0002_2040, 32'h0000_0204, 1'b1, 1'b1},
      '{32'h0000_0210, 32'h0000_0100, 1'b1, 1'b0},
      '{32'h0000_0300, 32'h3000_0000, 1'b1, 1'b1},
      '{32'h3000_0020, 32'h0000_0304, 1'b1, 1'b1},
      '{32'h0000_0310, 32'h0000_0000, 1'b0, 1'b0},
      '{32'h0000_0320, 32'h0000_0100, 1'b1, 1'b1}
   };

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      logic [12:0] pb;
      logic [31:0] a, q;
      logic [31:0] pa1, pa2, pa3;
      logic [12:0] pp1, pp2, pp3;

      m_clear();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: empty table after reset
      probe(32'h0000_1230, "R1 reset lookup");
      @(negedge clk);
      chk("R1 no hit after reset", 32'(lk_hit), 32'd0);
      chk("R1 zero target after reset", lk_target, 32'd0);
      probe(32'hfff3_fff0, "R1 reset lookup high");

      // R5: not-taken indirect and taken direct branches do not train
      do_reset();
      pb = path_m;
      a = 32'h0000_3a50;
      step(a, 32'h0000_7770, 1'b0, 1'b1);
      q = pc_for(path_m, m_idx(pb, a), m_tag(pb, a), 32'h0);
      probe(q, "R5 not-taken indirect");
      chk("R5 not-taken indirect leaves no entry", 32'(lk_hit), 32'd0);
      pb = path_m;
      a = 32'h0000_5c60;
      step(a, 32'h0000_8880, 1'b1, 1'b0);
      q = pc_for(path_m, m_idx(pb, a), m_tag(pb, a), 32'h0);
      probe(q, "R5 direct taken");
      chk("R5 direct taken leaves no entry", 32'(lk_hit), 32'd0);

      // R2 R3: entry found through a different address with the same hash
      pb = path_m;
      a = 32'h0001_2340;
      step(a, 32'h0000_8880, 1'b1, 1'b1);
      q = pc_for(path_m, m_idx(pb, a), m_tag(pb, a), 32'habc0_020c);
      probe(q, "R3 alias");
      chk("R2 R3 alias hit", 32'(lk_hit), 32'd1);
      chk("R3 alias target", lk_target, 32'h0000_8880);
      probe(q ^ 32'h0000_0010, "R3 index bit");
      chk("R3 index bit flip misses", 32'(lk_hit), 32'd0);
      probe(q ^ 32'h0000_0400, "R3 tag bit");
      chk("R3 tag bit flip misses", 32'(lk_hit), 32'd0);
      // R8: repeat the first lookup after other lookups
      probe(q, "R8 repeat");
      chk("R8 repeated lookup unchanged", lk_target, 32'h0000_8880);

      // R6: replacement inside set 5
      do_reset();
      pa1 = pc_for(path_m, 5'd5, 8'h11, 32'h0); pp1 = path_m;
      step(pa1, 32'h0000_1110, 1'b1, 1'b1);
      pa2 = pc_for(path_m, 5'd5, 8'h22, 32'h0); pp2 = path_m;
      step(pa2, 32'h0000_2220, 1'b1, 1'b1);
      pa3 = pc_for(path_m, 5'd5, 8'h33, 32'h0); pp3 = path_m;
      step(pa3, 32'h0000_3330, 1'b1, 1'b1);
      probe(pc_for(path_m, 5'd5, 8'h11, 32'h0), "R6 oldest");
      chk("R6 oldest way evicted", 32'(lk_hit), 32'd0);
      probe(pc_for(path_m, 5'd5, 8'h22, 32'h0), "R6 second");
      chk("R6 second entry kept", lk_target, 32'h0000_2220);
      probe(pc_for(path_m, 5'd5, 8'h33, 32'h0), "R6 third");
      chk("R6 new entry present", lk_target, 32'h0000_3330);
      step(pc_for(path_m, 5'd5, 8'h22, 32'h0), 32'h0000_2440, 1'b1, 1'b1);
      step(pc_for(path_m, 5'd5, 8'h44, 32'h0), 32'h0000_4440, 1'b1, 1'b1);
      probe(pc_for(path_m, 5'd5, 8'h22, 32'h0), "R6 refreshed");
      chk("R6 refreshed entry rewritten in place", lk_target, 32'h0000_2440);
      probe(pc_for(path_m, 5'd5, 8'h33, 32'h0), "R6 stale");
      chk("R6 least recent entry evicted", 32'(lk_hit), 32'd0);
      probe(pc_for(path_m, 5'd5, 8'h44, 32'h0), "R6 newest");
      chk("R6 newest entry present", lk_target, 32'h0000_4440);

      // R7: upper bits from the shared last-value register
      do_reset();
      pb = path_m;
      a = 32'h0000_0a40;
      step(a, 32'h1230_0440, 1'b1, 1'b1);
      step(32'h0000_0b40, 32'h1230_0880, 1'b1, 1'b1);
      @(negedge clk);
      rt_valid = 1'b1; rt_pc = 32'h0000_0c40; rt_target = 32'h7770_0000;
      rt_taken = 1'b1; rt_indirect = 1'b0;
      #2;
      chk("R7 direct branch never flags", 32'(rt_hi_miss), 32'd0);
      @(posedge clk);
      m_retire(32'h0000_0c40, 32'h7770_0000, 1'b1, 1'b0);
      #1 rt_valid = 1'b0;
      @(negedge clk);
      rt_valid = 1'b1; rt_pc = 32'h0000_0d40; rt_target = 32'h4560_0100;
      rt_taken = 1'b1; rt_indirect = 1'b1;
      #2;
      chk("R7 new upper bits flag", 32'(rt_hi_miss), 32'd1);
      @(posedge clk);
      m_retire(32'h0000_0d40, 32'h4560_0100, 1'b1, 1'b1);
      #1 rt_valid = 1'b0;
      q = pc_for(path_m, m_idx(pb, a), m_tag(pb, a), 32'h0);
      probe(q, "R7 upper from last value");
      chk("R7 target takes latest upper bits", lk_target, 32'h4560_0440);

      // Vector walk: model comparison on a repeating branch pattern
      do_reset();
      for (int pass = 0; pass < 4; pass++) begin
         for (int i = 0; i < VEC_N; i++) begin
            step(VECS[i].pc, VECS[i].tgt, VECS[i].tk, VECS[i].ind);
         end
      end
      probe(32'h0000_0180, "R4 after walk");

      // R1: reset in mid-run clears training
      do_reset();
      probe(32'h0000_0180, "R1 reset mid-run");
      chk("R1 mid-run reset empties table", 32'(lk_hit), 32'd0);
      @(negedge clk);
      rt_valid = 1'b1; rt_pc = 32'h0000_0100; rt_target = 32'h0000_0200;
      rt_taken = 1'b1; rt_indirect = 1'b1;
      #2;
      chk("R1 last-value register cleared", 32'(rt_hi_miss), 32'd0);
      @(posedge clk);
      #1 rt_valid = 1'b0;

      done = 1'b1;
      summary();
      $finish;
   end
endmodule